// File: doc/BRIEF.md
# Scratchpad Operand Address Generator

This block produces the read addresses for the scratchpad memories of a multi-precision Montgomery multiplier. The datapath fetches three operands on every cycle. Two of them come from the dual-read operand memory, which holds the a, b and modulus integers. The third comes from the intermediate-result memory. Each of the three read ports has an index register of its own. A fourth index register of the same kind supplies the operand-memory write address used while operands are being loaded.

Each register is steered by a 2-bit code from the microcode word. The four codes are independent and all four registers update on the same clock edge. This lets operand addressing proceed in parallel with the multiply-add work, so the microprogram spends no instruction slots on address arithmetic.

The memories are sized at 4k words, where k is the operand length in datapath words. The parameter `K_WORDS` sets k, and the address width is the ceiling of log2(4k). The intermediate-result write address is not produced here; it travels down the arithmetic core's store pipeline instead.

Top module: `opaddr_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets all four address outputs to 0, whatever codes and constant are applied in that cycle.
- R2: Code 2'b00 (hold) on a channel leaves that channel's address unchanged at the next edge.
- R3: Code 2'b01 (load) stores the constant bus value when that value is below DEPTH = 4*K_WORDS.
- R4: Code 2'b01 with a constant bus value of DEPTH or more stores the value minus DEPTH, so that the address stays inside the memory.
- R5: Code 2'b10 (clear) sets the channel's address to 0 at the next edge.
- R6: Code 2'b11 (increment) adds one to the address, and DEPTH-1 wraps to 0.
- R7: The four channels are independent. Each address depends only on its own code (channel order: operand read 0, operand read 1, result read, operand write), and all four update on the same edge.
- R8: No address output ever reaches DEPTH or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opa_rd0_op | input | 2 | Code for operand memory read port 0 |
| opa_rd1_op | input | 2 | Code for operand memory read port 1 |
| res_rd_op | input | 2 | Code for result memory read port |
| opa_wr_op | input | 2 | Code for operand memory write address |
| const_bus | input | AW | Shared constant value used by load |
| opa_rd0_addr | output | AW | Operand memory read port 0 address |
| opa_rd1_addr | output | AW | Operand memory read port 1 address |
| res_rd_addr | output | AW | Result memory read port address |
| opa_wr_addr | output | AW | Operand memory write address |

## Verification
The bench builds two instances side by side. The first uses K_WORDS=6, which gives a depth of 24 and a 5-bit address; this exercises the compare-based wrap and the folding of out-of-range constants 24 to 31. The second uses K_WORDS=4, which gives a depth of 16 and selects the power-of-two variant, where wrap and load need no correction. Both instances receive every combination of the four channel codes, run long increment stretches past the wrap point, and see loads of every constant value.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;

   typedef enum logic [1:0] {
      IDX_HOLD  = 2'b00,
      IDX_LOAD  = 2'b01,
      IDX_CLEAR = 2'b10,
      IDX_INC   = 2'b11
   } idx_op_e;

   typedef struct packed {
      logic clr;
      logic ld;
      logic inc;
   } idx_act_t;

   localparam int NUM_CH    = 4;
   localparam int CH_OPA_R0 = 0;
   localparam int CH_OPA_R1 = 1;
   localparam int CH_RES_R  = 2;
   localparam int CH_OPA_W  = 3;

   function automatic bool_is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/idx_decode.sv
module idx_decode
   import opaddr_pkg::*;
(
   input  logic [1:0] op,
   output idx_act_t   act
);

   always_comb begin
      act = '0;
      unique case (idx_op_e'(op))
         IDX_HOLD:  act = '0;
         IDX_LOAD:  act.ld  = 1'b1;
         IDX_CLEAR: act.clr = 1'b1;
         IDX_INC:   act.inc = 1'b1;
         default:   act = '0;
      endcase
   end

endmodule

// File: rtl/ld_fold.sv
module ld_fold #(
   parameter int DEPTH = 24,
   parameter int AW    = 5
) (
   input  logic [AW-1:0] raw,
   output logic [AW-1:0] folded
);

   localparam bit FULL = ((1 << AW) == DEPTH);

   generate
      if (FULL) begin : g_full
         assign folded = raw;
      end else begin : g_part
         localparam logic [AW-1:0] DEPTH_V = AW'(DEPTH);
         always_comb begin
            if (raw >= DEPTH_V) folded = raw - DEPTH_V;
            else                folded = raw;
         end
      end
   endgenerate

endmodule

// File: rtl/idx_reg.sv
module idx_reg
   import opaddr_pkg::*;
#(
   parameter int DEPTH = 24,
   parameter int AW    = 5
) (
   input  logic          clk,
   input  logic          rst,
   input  idx_act_t      act,
   input  logic [AW-1:0] ld_val,
   output logic [AW-1:0] q
);

   localparam bit FULL = ((1 << AW) == DEPTH);
   logic [AW-1:0] q_inc;

   generate
      if (FULL) begin : g_full
         assign q_inc = q + AW'(1);
      end else begin : g_part
         localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
         assign q_inc = (q == LAST) ? '0 : q + AW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)          q <= '0;
      else if (act.clr) q <= '0;
      else if (act.ld)  q <= ld_val;
      else if (act.inc) q <= q_inc;
   end

endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen
   import opaddr_pkg::*;
#(
   parameter  int K_WORDS = 6,
   localparam int DEPTH   = 4 * K_WORDS,
   localparam int AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [1:0]    opa_rd0_op,
   input  logic [1:0]    opa_rd1_op,
   input  logic [1:0]    res_rd_op,
   input  logic [1:0]    opa_wr_op,
   input  logic [AW-1:0] const_bus,
   output logic [AW-1:0] opa_rd0_addr,
   output logic [AW-1:0] opa_rd1_addr,
   output logic [AW-1:0] res_rd_addr,
   output logic [AW-1:0] opa_wr_addr
);

   generate
      if (K_WORDS < 1) begin : g_bad_k
         $error("opaddr_gen: K_WORDS must be at least 1");
      end
   endgenerate

   logic [NUM_CH-1:0][1:0]    op_vec;
   logic [NUM_CH-1:0][AW-1:0] addr_vec;
   idx_act_t                  act [NUM_CH];
   logic [AW-1:0]             ld_norm;

   assign op_vec[CH_OPA_R0] = opa_rd0_op;
   assign op_vec[CH_OPA_R1] = opa_rd1_op;
   assign op_vec[CH_RES_R]  = res_rd_op;
   assign op_vec[CH_OPA_W]  = opa_wr_op;

   ld_fold #(.DEPTH(DEPTH), .AW(AW)) u_fold (
      .raw    (const_bus),
      .folded (ld_norm)
   );

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         idx_decode u_dec (
            .op  (op_vec[ch]),
            .act (act[ch])
         );
         idx_reg #(.DEPTH(DEPTH), .AW(AW)) u_reg (
            .clk    (clk),
            .rst    (rst),
            .act    (act[ch]),
            .ld_val (ld_norm),
            .q      (addr_vec[ch])
         );
      end
   endgenerate

   assign opa_rd0_addr = addr_vec[CH_OPA_R0];
   assign opa_rd1_addr = addr_vec[CH_OPA_R1];
   assign res_rd_addr  = addr_vec[CH_RES_R];
   assign opa_wr_addr  = addr_vec[CH_OPA_W];

endmodule

// File: rtl/opaddr_gen_chk.sv
module opaddr_gen_chk #(
   parameter int K_WORDS = 6,
   parameter int NCH     = 4,
   localparam int DEPTH  = 4 * K_WORDS,
   localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input logic                  clk,
   input logic                  rst,
   input logic [NCH-1:0][1:0]   op_vec,
   input logic [AW-1:0]         const_bus,
   input logic [NCH-1:0][AW-1:0] addr_vec
);

   logic past_rst_q;
   always_ff @(posedge clk) past_rst_q <= rst;

   generate
      for (genvar ch = 0; ch < NCH; ch++) begin : g_c
         // R1
         p_reset_r1: assert property (@(posedge clk) disable iff (rst)
            past_rst_q |-> addr_vec[ch] == '0);
         p_hold_r2: assert property (@(posedge clk) disable iff (rst)
            (!past_rst_q && $past(op_vec[ch]) == 2'b00) |-> $stable(addr_vec[ch]));
         p_load_r3: assert property (@(posedge clk) disable iff (rst)
            (!past_rst_q && $past(op_vec[ch]) == 2'b01 && int'($past(const_bus)) < DEPTH)
            |-> addr_vec[ch] == $past(const_bus));
         p_fold_r4: assert property (@(posedge clk) disable iff (rst)
            (!past_rst_q && $past(op_vec[ch]) == 2'b01 && int'($past(const_bus)) >= DEPTH)
            |-> int'(addr_vec[ch]) == int'($past(const_bus)) - DEPTH);
         p_clear_r5: assert property (@(posedge clk) disable iff (rst)
            (!past_rst_q && $past(op_vec[ch]) == 2'b10) |-> addr_vec[ch] == '0);
         p_inc_r6: assert property (@(posedge clk) disable iff (rst)
            (!past_rst_q && $past(op_vec[ch]) == 2'b11)
            |-> int'(addr_vec[ch]) == (int'($past(addr_vec[ch])) + 1) % DEPTH);
         p_range_r8: assert property (@(posedge clk) disable iff (rst)
            int'(addr_vec[ch]) < DEPTH);
      end
   endgenerate

endmodule

bind opaddr_gen opaddr_gen_chk #(.K_WORDS(K_WORDS), .NCH(opaddr_pkg::NUM_CH)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .op_vec    (op_vec),
   .const_bus (const_bus),
   .addr_vec  (addr_vec)
);

// File: tb/sim_opaddr_gen.sv
module sim_opaddr_gen;

   localparam int CLK_PERIOD = 10;
   localparam int KA = 6;
   localparam int DA = 4 * KA;
   localparam int AWA = $clog2(DA);
   localparam int KB = 4;
   localparam int DB = 4 * KB;
   localparam int AWB = $clog2(DB);

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [3:0][1:0] ops = '0;
   logic [AWA-1:0] cbus = '0;
   logic [AWA-1:0] a0, a1, a2, a3;
   logic [AWB-1:0] b0, b1, b2, b3;

   int n_checks = 0;
   int n_fail = 0;
   int exp_a [4];
   int exp_b [4];
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   opaddr_gen #(.K_WORDS(KA)) u0 (
      .clk(clk), .rst(rst),
      .opa_rd0_op(ops[0]), .opa_rd1_op(ops[1]), .res_rd_op(ops[2]), .opa_wr_op(ops[3]),
      .const_bus(cbus),
      .opa_rd0_addr(a0), .opa_rd1_addr(a1), .res_rd_addr(a2), .opa_wr_addr(a3));

   opaddr_gen #(.K_WORDS(KB)) u1 (
      .clk(clk), .rst(rst),
      .opa_rd0_op(ops[0]), .opa_rd1_op(ops[1]), .res_rd_op(ops[2]), .opa_wr_op(ops[3]),
      .const_bus(cbus[AWB-1:0]),
      .opa_rd0_addr(b0), .opa_rd1_addr(b1), .res_rd_addr(b2), .opa_wr_addr(b3));

   function automatic int nxt(int code, int cur, int c, int depth);
      case (code)
         0: return cur;
         1: return (c >= depth) ? c - depth : c;
         2: return 0;
         default: return (cur == depth - 1) ? 0 : cur + 1;
      endcase
   endfunction

   function automatic string tag(int code, int c, int depth);
      case (code)
         0: return "R2";
         1: return (c >= depth) ? "R4" : "R3";
         2: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic chk(string req, int act, int expv);
      n_checks++;
      if (act != expv) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   function automatic int got_a(int ch);
      case (ch) 0: return int'(a0); 1: return int'(a1); 2: return int'(a2); default: return int'(a3); endcase
   endfunction
   function automatic int got_b(int ch);
      case (ch) 0: return int'(b0); 1: return int'(b1); 2: return int'(b2); default: return int'(b3); endcase
   endfunction

   // Apply codes and constant for one edge, then compare every channel (R7: each channel is modelled on its own code only).
   task automatic step(logic [3:0][1:0] o, int c);
      string ta [4];
      string tb [4];
      ops = o;
      cbus = AWA'(c);
      for (int ch = 0; ch < 4; ch++) begin
         ta[ch] = tag(int'(o[ch]), c, DA);
         tb[ch] = tag(int'(o[ch]), c % DB, DB);
         exp_a[ch] = nxt(int'(o[ch]), exp_a[ch], c, DA);
         exp_b[ch] = nxt(int'(o[ch]), exp_b[ch], c % DB, DB);
      end
      @(posedge clk);
      #1;
      for (int ch = 0; ch < 4; ch++) begin
         chk({ta[ch], "/R7 depth24"}, got_a(ch), exp_a[ch]);
         chk({tb[ch], "/R7 depth16"}, got_b(ch), exp_b[ch]);
         n_checks++;
         if (got_a(ch) >= DA || got_b(ch) >= DB) begin
            n_fail++;
            $display("FAIL R8 actual=%0d/%0d expected below %0d/%0d", got_a(ch), got_b(ch), DA, DB);
         end
      end
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: reset with load codes and a nonzero constant still yields zero
      ops = {4{2'b01}};
      cbus = AWA'(9);
      @(negedge clk);
      @(posedge clk);
      @(posedge clk);
      #1;
      for (int ch = 0; ch < 4; ch++) begin
         chk("R1 depth24", got_a(ch), 0);
         chk("R1 depth16", got_b(ch), 0);
         exp_a[ch] = 0;
         exp_b[ch] = 0;
      end
      @(negedge clk);
      rst = 1'b0;

      // R3/R4: load every constant value on all channels
      for (int c = 0; c < (1 << AWA); c++) step({4{2'b01}}, c);

      // R6: long increment run past both wrap points
      step({4{2'b10}}, 0);
      for (int i = 0; i < 3 * DA; i++) step({4{2'b11}}, 0);

      // R2..R7: every code combination across channels, several constants
      for (int s = 0; s < 2048; s++) begin
         logic [7:0] sel;
         sel = 8'(s ^ (s >> 8) * 37);
         step(sel, (s * 7 + 3) % (1 << AWA));
      end

      // R4: fold of the largest constant, then increment from the folded value
      step({4{2'b01}}, (1 << AWA) - 1);
      step({2'b11, 2'b00, 2'b10, 2'b11}, 0);

      // R1: reset in mid-run clears all channels
      ops = {4{2'b11}};
      rst = 1'b1;
      @(posedge clk);
      #1;
      for (int ch = 0; ch < 4; ch++) begin
         chk("R1 depth24 mid", got_a(ch), 0);
         chk("R1 depth16 mid", got_b(ch), 0);
      end
      @(negedge clk);
      rst = 1'b0;

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule